// File: doc/BRIEF.md
# Two-Wire Serial Memory Transaction Sequencer

This block is the byte-level controller of a two-wire serial memory slave. A bit-level front end, not part of this block, turns the pin activity into events: start and stop conditions, a completed received byte, the bit position inside the current byte, and the end of each ninth (acknowledge) clock together with the level the master drove there. From these events the sequencer decides when to acknowledge. It keeps a 16-bit address counter, gathers page-write data in a page buffer and copies that buffer into the storage array when a valid stop arrives. It then holds a timed internal write cycle. It also supplies read data for current-address, random and sequential reads.

The first byte of every transfer carries a 7-bit device identifier in bits 7..1 and a direction bit in bit 0 (1 = read, 0 = write). A write sends the high address byte, then the low address byte, then data. A random read is a write that carries only the two address bytes, followed by a repeated start and a read. The storage array is a register array indexed by the low bits of the address counter. During the timed write cycle the device ignores its own identifier, so a master can find out when the write has finished by polling for an acknowledge.

Top module: `eeprom_txn_seq`

## Requirements
- R1: After reset, ackOut and txEn are 0 and the address counter is 0, so a current-address read returns the byte stored at index 0.
- R2: A first byte whose bits 7..1 equal DEV_ID is acknowledged (ackOut = 1 from the cycle after rxValid until the end of the ninth clock). A first byte with any other identifier is not acknowledged, and no further byte of that transfer is acknowledged.
- R3: In a write, the two bytes that follow the identifier are acknowledged and loaded into the address counter, high byte first.
- R4: Each data byte of a write is acknowledged and stored in the page buffer at the counter's column (the address modulo PAGE). Only the column increments, wrapping inside the page, so a later byte overwrites an earlier one at the same column.
- R5: A stop with bitPos = 0 that arrives after at least one data byte and its ninth clock copies every buffered byte into the array and leaves all other bytes unchanged.
- R6: A stop with bitPos != 0, a stop before the first data byte has finished its ninth clock, or a repeated start during data loading leaves the array unchanged and starts no write cycle.
- R7: After a committing stop, an identifier byte whose rxValid falls in any of the next WR_CYCLES cycles is not acknowledged. One in the following cycle is acknowledged.
- R8: A read identifier (bit 0 = 1) is acknowledged. After its ninth clock, txEn = 1 and txByte holds the array byte at the address counter.
- R9: A master acknowledge (mstAck = 1) in the ninth clock of a read byte advances the counter by one, wrapping from 16'hFFFF to 0, and presents the next byte.
- R10: A master no-acknowledge in the ninth clock still advances the counter, drops txEn, and causes every byte until the next start or stop to be left unacknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startEv | input | 1 | One-cycle pulse: start or repeated start seen |
| stopEv | input | 1 | One-cycle pulse: stop seen |
| bitPos | input | 4 | Bits of the current byte already clocked (0 at a byte boundary, 8 in the ninth clock) |
| rxValid | input | 1 | One-cycle pulse: a byte from the master is complete |
| rxByte | input | 8 | Byte received from the master, valid with rxValid |
| ackSlotDone | input | 1 | One-cycle pulse: the ninth clock of a byte has ended |
| mstAck | input | 1 | Master drove acknowledge in that ninth clock (1 = acknowledge) |
| ackOut | output | 1 | Slave acknowledges the byte just received |
| txEn | output | 1 | Slave is driving read data |
| txByte | output | 8 | Read data byte to shift out |

## Verification
The timed write cycle can end in the same cycle in which the next identifier byte completes. The write is committed, and the bench then places rxValid exactly on the last busy cycle, which must give a no-acknowledge, and in a second run one cycle later, which must give an acknowledge. The cycle of each run is counted from the committing stop, and the two outcomes bound the busy window from both sides. A sweep of page writes, at every starting column and with lengths that run past the page size, is then read back in full against an arithmetic model of the array.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic wrBuf;
    logic clrBuf;
    logic commit;
    logic advRead;
    logic loadTx;
  } seqStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_AHI,
    S_ALO,
    S_WDAT,
    S_RD,
    S_DROP
  } seqState_t;

endpackage

// File: rtl/eeprom_seq_ctl.sv
module eeprom_seq_ctl
  import eeprom_seq_pkg::*;
#(
  parameter logic [6:0] DEV_ID    = 7'h50,
  parameter int         WR_CYCLES = 250000,
  parameter int         BP_W      = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startEv,
  input  logic            stopEv,
  input  logic [BP_W-1:0] bitPos,
  input  logic            rxValid,
  input  logic [7:0]      rxByte,
  input  logic            ackSlotDone,
  input  logic            mstAck,
  output seqStrobe_t      strb,
  output logic            ackOut,
  output logic            rdActive,
  output logic            busy
);

  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  seqState_t        st, stN;
  logic             wrPend, wrPendN;
  logic             rdPend, rdPendN;
  logic             haveFull, fullN;
  logic             ackN;
  logic             busyStart;
  logic [CNT_W-1:0] wrCnt;

  always_comb begin
    strb      = '0;
    stN       = st;
    ackN      = ackOut;
    wrPendN   = wrPend;
    rdPendN   = rdPend;
    fullN     = haveFull;
    busyStart = 1'b0;

    if (ackSlotDone) begin
      ackN = 1'b0;
      if (wrPend) begin
        fullN   = 1'b1;
        wrPendN = 1'b0;
      end else if (rdPend) begin
        strb.loadTx = 1'b1;
        rdPendN     = 1'b0;
      end else if (st == S_RD) begin
        strb.advRead = 1'b1;
        if (!mstAck) stN = S_DROP;
      end
    end

    if (rxValid) begin
      unique case (st)
        S_DEV: begin
          if (!busy && rxByte[7:1] == DEV_ID) begin
            ackN = 1'b1;
            if (rxByte[0]) begin
              stN     = S_RD;
              rdPendN = 1'b1;
            end else begin
              stN = S_AHI;
            end
          end else begin
            stN = S_DROP;
          end
        end
        S_AHI: begin
          ackN        = 1'b1;
          strb.loadHi = 1'b1;
          stN         = S_ALO;
        end
        S_ALO: begin
          ackN        = 1'b1;
          strb.loadLo = 1'b1;
          stN         = S_WDAT;
        end
        S_WDAT: begin
          ackN       = 1'b1;
          strb.wrBuf = 1'b1;
          wrPendN    = 1'b1;
        end
        default: ;
      endcase
    end

    if (stopEv) begin
      if (st == S_WDAT) begin
        if (haveFull && !wrPend && bitPos == '0) begin
          strb.commit = 1'b1;
          busyStart   = 1'b1;
        end else begin
          strb.clrBuf = 1'b1;
        end
      end
      stN     = S_IDLE;
      ackN    = 1'b0;
      wrPendN = 1'b0;
      rdPendN = 1'b0;
      fullN   = 1'b0;
    end else if (startEv) begin
      if (st == S_WDAT) strb.clrBuf = 1'b1;
      stN     = S_DEV;
      ackN    = 1'b0;
      wrPendN = 1'b0;
      rdPendN = 1'b0;
      fullN   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= S_IDLE;
      ackOut   <= 1'b0;
      wrPend   <= 1'b0;
      rdPend   <= 1'b0;
      haveFull <= 1'b0;
    end else begin
      st       <= stN;
      ackOut   <= ackN;
      wrPend   <= wrPendN;
      rdPend   <= rdPendN;
      haveFull <= fullN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      wrCnt <= '0;
    end else if (busyStart) begin
      busy  <= 1'b1;
      wrCnt <= CNT_W'(WR_CYCLES - 1);
    end else if (busy) begin
      if (wrCnt == '0) busy <= 1'b0;
      else             wrCnt <= wrCnt - 1'b1;
    end
  end

  assign rdActive = (st == S_RD) && !rdPend;

endmodule

// File: rtl/eeprom_seq_dp.sv
module eeprom_seq_dp
  import eeprom_seq_pkg::*;
#(
  parameter int PAGE      = 64,
  parameter int MEM_DEPTH = 256,
  parameter int AW        = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  input  logic [7:0] rxByte,
  output logic [7:0] txByte
);

  localparam int PW = $clog2(PAGE);
  localparam int MW = $clog2(MEM_DEPTH);

  logic [7:0]    addrHi;
  logic [AW-1:0] addrCnt;
  logic [AW-1:0] addrInc;
  logic [PW-1:0] colNext;
  logic [MW-PW-1:0] pageTag;
  logic [7:0]    bufData [PAGE];
  logic [PAGE-1:0] bufValid;
  logic [7:0]    mem [MEM_DEPTH];

  assign addrInc = addrCnt + AW'(1);
  assign colNext = addrCnt[PW-1:0] + PW'(1);
  assign pageTag = addrCnt[MW-1:PW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHi  <= '0;
      addrCnt <= '0;
    end else begin
      if (strb.loadHi) addrHi <= rxByte;
      if (strb.loadLo)
        addrCnt <= AW'({addrHi, rxByte});
      else if (strb.wrBuf)
        addrCnt <= {addrCnt[AW-1:PW], colNext};
      else if (strb.advRead)
        addrCnt <= addrInc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufValid <= '0;
      for (int i = 0; i < PAGE; i++) bufData[i] <= '0;
    end else if (strb.wrBuf) begin
      bufData[addrCnt[PW-1:0]]  <= rxByte;
      bufValid[addrCnt[PW-1:0]] <= 1'b1;
    end else if (strb.commit || strb.clrBuf) begin
      bufValid <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
    end else if (strb.commit) begin
      for (int i = 0; i < PAGE; i++)
        if (bufValid[i]) mem[{pageTag, PW'(i)}] <= bufData[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txByte <= '0;
    else if (strb.loadTx)  txByte <= mem[addrCnt[MW-1:0]];
    else if (strb.advRead) txByte <= mem[addrInc[MW-1:0]];
  end

endmodule

// File: rtl/eeprom_txn_seq.sv
module eeprom_txn_seq
  import eeprom_seq_pkg::*;
#(
  parameter logic [6:0] DEV_ID    = 7'h50,
  parameter int         PAGE      = 64,
  parameter int         MEM_DEPTH = 256,
  parameter int         WR_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic [3:0] bitPos,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       ackSlotDone,
  input  logic       mstAck,
  output logic       ackOut,
  output logic       txEn,
  output logic [7:0] txByte
);

  seqStrobe_t strb;
  logic       rdActive;
  logic       wrBusy;

  eeprom_seq_ctl #(
    .DEV_ID   (DEV_ID),
    .WR_CYCLES(WR_CYCLES),
    .BP_W     (4)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .startEv    (startEv),
    .stopEv     (stopEv),
    .bitPos     (bitPos),
    .rxValid    (rxValid),
    .rxByte     (rxByte),
    .ackSlotDone(ackSlotDone),
    .mstAck     (mstAck),
    .strb       (strb),
    .ackOut     (ackOut),
    .rdActive   (rdActive),
    .busy       (wrBusy)
  );

  eeprom_seq_dp #(
    .PAGE     (PAGE),
    .MEM_DEPTH(MEM_DEPTH),
    .AW       (16)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .rxByte(rxByte),
    .txByte(txByte)
  );

  assign txEn = rdActive && !wrBusy;

endmodule

// File: rtl/eeprom_txn_seq_chk.sv
module eeprom_txn_seq_chk #(
  parameter int WR_CYCLES = 250000
) (
  input logic clk,
  input logic rstN,
  input logic rxValid,
  input logic stopEv,
  input logic ackSlotDone,
  input logic mstAck,
  input logic ackOut,
  input logic txEn,
  input logic wrBusy
);

  localparam int LEN_W = $clog2(WR_CYCLES + 2);
  logic [LEN_W-1:0] busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       busyLen <= '0;
    else if (wrBusy) busyLen <= busyLen + 1'b1;
    else             busyLen <= '0;
  end

  // R2: an acknowledge only ever follows a received byte
  p_ack_after_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOut) |-> $past(rxValid));

  // R2: the acknowledge is released at the end of the ninth clock
  p_ack_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ackOut && ackSlotDone && !rxValid) |=> !ackOut);

  // R5: a write cycle is only launched by a stop
  p_busy_from_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrBusy) |-> $past(stopEv));

  // R7: no acknowledge to a byte that completes while busy
  p_busy_nack_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrBusy && rxValid) |=> !ackOut);

  // R7: the write cycle lasts exactly WR_CYCLES cycles
  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrBusy) |-> (busyLen == LEN_W'(WR_CYCLES)));

  // R10: a master no-acknowledge ends the data drive
  p_read_end_r10: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && ackSlotDone && !mstAck) |=> !txEn);

endmodule

bind eeprom_txn_seq eeprom_txn_seq_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rxValid    (rxValid),
  .stopEv     (stopEv),
  .ackSlotDone(ackSlotDone),
  .mstAck     (mstAck),
  .ackOut     (ackOut),
  .txEn       (txEn),
  .wrBusy     (wrBusy)
);

// File: tb/tb_eeprom_txn_seq.sv
module tb_eeprom_txn_seq;

  localparam logic [6:0] DEV = 7'h50;
  localparam int P  = 8;
  localparam int M  = 64;
  localparam int WR = 20;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startEv = 1'b0, stopEv = 1'b0, rxValid = 1'b0, ackSlotDone = 1'b0, mstAck = 1'b0;
  logic [3:0] bitPos = '0;
  logic [7:0] rxByte = '0;
  logic ackOut, txEn;
  logic [7:0] txByte;

  int nChk = 0;
  int nFail = 0;
  logic [7:0] mdl [M];
  logic [15:0] mCnt;

  always #10 clk = ~clk;

  eeprom_txn_seq #(.DEV_ID(DEV), .PAGE(P), .MEM_DEPTH(M), .WR_CYCLES(WR)) dut (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv), .bitPos(bitPos),
    .rxValid(rxValid), .rxByte(rxByte), .ackSlotDone(ackSlotDone), .mstAck(mstAck),
    .ackOut(ackOut), .txEn(txEn), .txByte(txByte));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulseStart();
    startEv = 1'b1; @(negedge clk); startEv = 1'b0;
  endtask

  task automatic pulseStop(input logic [3:0] bp);
    bitPos = bp; stopEv = 1'b1; @(negedge clk); stopEv = 1'b0; bitPos = '0;
  endtask

  task automatic sendByte(input logic [7:0] b, output bit a);
    bitPos = 4'd8; rxValid = 1'b1; rxByte = b;
    @(negedge clk);
    rxValid = 1'b0;
    a = ackOut;
    ackSlotDone = 1'b1; mstAck = 1'b0;
    @(negedge clk);
    ackSlotDone = 1'b0; bitPos = '0;
  endtask

  task automatic setAddr(input logic [15:0] a);
    bit k;
    pulseStart();
    sendByte({DEV, 1'b0}, k); chk(k, "R2 id ack", k, 1);
    sendByte(a[15:8], k);     chk(k, "R3 high addr ack", k, 1);
    sendByte(a[7:0], k);      chk(k, "R3 low addr ack", k, 1);
  endtask

  task automatic writeSeq(input logic [15:0] a, input int n, input int seed, input bit doWait);
    bit k;
    logic [PW-1:0] col = a[PW-1:0];
    setAddr(a);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'((seed * 13 + i * 29 + 1) & 255);
      sendByte(d, k);
      chk(k, "R4 data ack", k, 1);
      mdl[{a[5:PW], col}] = d;
      col = col + 1'b1;
    end
    mCnt = {a[15:PW], col};
    pulseStop(4'd0);
    if (doWait) repeat (WR + 2) @(negedge clk);
  endtask

  task automatic readOut(input int n);
    for (int i = 0; i < n; i++) begin
      chk(txEn == 1'b1, "R8 txEn during read", txEn, 1);
      chk(txByte == mdl[mCnt[5:0]], (i == 0) ? "R8 first read byte" : "R9 sequential byte",
          txByte, mdl[mCnt[5:0]]);
      ackSlotDone = 1'b1; mstAck = (i < n - 1);
      @(negedge clk);
      ackSlotDone = 1'b0; mstAck = 1'b0;
      mCnt = mCnt + 16'd1;
    end
    chk(txEn == 1'b0, "R10 txEn dropped after nack", txEn, 0);
  endtask

  task automatic readRand(input logic [15:0] a, input int n);
    bit k;
    setAddr(a);
    pulseStart();
    sendByte({DEV, 1'b1}, k); chk(k, "R8 read id ack", k, 1);
    mCnt = a;
    readOut(n);
    pulseStop(4'd0);
  endtask

  task automatic readCur(input int n, input string tag);
    bit k;
    pulseStart();
    sendByte({DEV, 1'b1}, k); chk(k, tag, k, 1);
    readOut(n);
    pulseStop(4'd0);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    bit k;
    for (int i = 0; i < M; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(ackOut == 1'b0, "R1 ackOut after reset", ackOut, 0);
    chk(txEn == 1'b0, "R1 txEn after reset", txEn, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: current-address read starts at 0
    mCnt = 16'h0000;
    readCur(1, "R1 read id ack after reset");

    // R4/R5: page writes from every column, several overflowing the page
    for (int s = 0; s < P; s++)
      writeSeq(16'h2300 + 16'(s * P + s), s + 3, s, 1'b1);
    readRand(16'h2300, M);
    // counter continues past the top of the array index
    readCur(2, "R9 current read ack");

    // R6: stop in the middle of a data byte
    setAddr(16'h2308);
    sendByte(8'hA5, k);
    sendByte(8'h5A, k);
    pulseStop(4'd3);
    pulseStart();
    sendByte({DEV, 1'b0}, k);
    chk(k, "R6 no busy after mid-byte stop", k, 1);
    pulseStop(4'd0);
    readRand(16'h2308, 2);

    // R6: stop with only the address bytes
    setAddr(16'h2310);
    pulseStop(4'd0);
    pulseStart();
    sendByte({DEV, 1'b0}, k);
    chk(k, "R6 no busy after address-only stop", k, 1);
    pulseStop(4'd0);

    // R6: one data byte, then repeated start
    setAddr(16'h2318);
    sendByte(8'hC3, k);
    pulseStart();
    sendByte({DEV, 1'b1}, k);
    chk(k, "R6 read id ack after repeated start", k, 1);
    mCnt = 16'h2319;
    readOut(1);
    pulseStop(4'd0);
    readRand(16'h2318, 1);

    // R2: foreign identifier and the bytes after it
    pulseStart();
    sendByte({7'h23, 1'b0}, k); chk(!k, "R2 foreign id nack", k, 0);
    sendByte(8'h00, k);         chk(!k, "R2 byte after foreign id nack", k, 0);
    pulseStop(4'd0);

    // R7: identifier on the last busy cycle
    writeSeq(16'h2320, 1, 40, 1'b0);
    pulseStart();
    repeat (WR - 2) @(negedge clk);
    sendByte({DEV, 1'b0}, k);
    chk(!k, "R7 nack on last busy cycle", k, 0);
    pulseStop(4'd0);
    repeat (WR + 2) @(negedge clk);

    // R7: identifier one cycle after the write cycle
    writeSeq(16'h2321, 1, 41, 1'b0);
    pulseStart();
    repeat (WR - 1) @(negedge clk);
    sendByte({DEV, 1'b0}, k);
    chk(k, "R7 ack after busy ends", k, 1);
    pulseStop(4'd0);
    readRand(16'h2320, 2);

    // R9: counter wraps from FFFF to 0
    writeSeq(16'hFFFF, 1, 50, 1'b1);
    writeSeq(16'h0000, 3, 51, 1'b1);
    readRand(16'hFFFF, 3);
    chk(mCnt == 16'h0002, "R9 model wrap", mCnt, 2);
    // R10: counter advanced by the nacked byte
    readCur(1, "R10 read id ack");

    // R10: bytes after master nack are not acknowledged
    pulseStart();
    sendByte({DEV, 1'b1}, k);
    ackSlotDone = 1'b1; mstAck = 1'b0;
    @(negedge clk);
    ackSlotDone = 1'b0;
    sendByte(8'h11, k);
    chk(!k, "R10 no ack after read end", k, 0);
    pulseStop(4'd0);

    report();
  end

endmodule